// File: doc/BRIEF.md
# Dual Data Address Generator

This block forms operand addresses for two memories at once. It holds two address generators that do not depend on each other. One feeds the data memory and the other feeds the program memory, so that two operand fetches can start in the same clock cycle. Each generator owns a file of index registers and a file of modifier registers, and software loads them through a single shared write port. An access request names one index register, one modifier register and an access mode. The generator returns a registered address with a strobe one cycle later. When the mode asks for it, the generator also steps the chosen index register by the modifier, which makes walking an array cost no arithmetic-unit cycles.

The program-memory generator also serves as the source of targets for indirect jumps. A jump request on its port forms index plus modifier and presents the result on a separate jump-target output. The program-memory data strobe stays low for that request. Each generator decodes its access mode in a small enumerated decoder with four states: offset, post-modify, jump and none.

Top module: `dual_dag`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every index and modifier register of both generators to zero and drives `dm_valid`, `pm_valid` and `jmp_valid` low on the next cycle.
- R2: A write with `wr_en` high loads `wr_data` into one register. `wr_gen` picks the generator (0 = data, 1 = program), `wr_is_mod` picks the file (0 = index, 1 = modifier) and `wr_sel` picks the entry. The new value takes effect from the following cycle.
- R3: Offset mode (mode code 0): in the cycle after the request, the port's address output equals index + modifier and its strobe is high. The index register does not change.
- R4: Post-modify mode (mode code 1): in the cycle after the request, the address equals the index value before the update and the strobe is high. The index register becomes index + modifier.
- R5: The two generators serve requests in the same cycle with separate register files. A request or an update on one generator never changes the other generator's registers or outputs.
- R6: Jump mode (mode code 2) on the program port: one cycle later, `jmp_addr` equals index + modifier and `jmp_valid` is high, while `pm_valid` stays low. No register changes.
- R7: The data port ignores mode code 2, and both ports ignore mode code 3. Such requests raise no strobe and change no register.
- R8: If a software write and a post-modify update target the same index register in the same cycle, the register takes the software value.
- R9: An access reads the register contents as they stood before any write made in the same cycle.
- R10: Index arithmetic wraps modulo 2^AW, and a modifier counts as a two's-complement value, so a negative modifier moves the index downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_gen | input | 1 | Write target generator: 0 data, 1 program |
| wr_is_mod | input | 1 | Write target file: 0 index, 1 modifier |
| wr_sel | input | clog2(NREG) | Write target entry |
| wr_data | input | AW | Write value |
| dm_req | input | 1 | Data-port access request |
| dm_mode | input | 2 | Data-port mode: 0 offset, 1 post-modify, 2/3 ignored |
| dm_isel | input | clog2(NREG) | Data-port index select |
| dm_msel | input | clog2(NREG) | Data-port modifier select |
| pm_req | input | 1 | Program-port access request |
| pm_mode | input | 2 | Program-port mode: 0 offset, 1 post-modify, 2 jump, 3 ignored |
| pm_isel | input | clog2(NREG) | Program-port index select |
| pm_msel | input | clog2(NREG) | Program-port modifier select |
| dm_addr | output | AW | Data-memory address |
| dm_valid | output | 1 | Data-memory address strobe |
| pm_addr | output | AW | Program-memory address |
| pm_valid | output | 1 | Program-memory address strobe |
| jmp_addr | output | AW | Indirect jump target |
| jmp_valid | output | 1 | Jump target strobe |

## Verification
The strobe properties assume that every request input is either held low or carries a fully defined mode code. They also assume that reset is asserted from the first edge until the registers settle. The bench drives all inputs on the falling edge and parks the requests low between operations, so each strobe property sees exactly one request per rising edge. The assertions check only strobes and never address values, because an address value depends on register contents that the bench predicts on its own. Collisions are forced only where a requirement names them, namely a write and an update, or a write and a read, on the same register.

// File: rtl/dag_pkg.sv
package dag_pkg;
    // Access mode decoded by each generator
    typedef enum logic [1:0] {
        ACC_OFFSET  = 2'd0,
        ACC_POSTMOD = 2'd1,
        ACC_JUMP    = 2'd2,
        ACC_NONE    = 2'd3
    } acc_mode_e;
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile #(
    parameter int AW   = 32,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_is_mod,
    input  logic [$clog2(NREG)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    upd_en,
    input  logic [$clog2(NREG)-1:0] upd_sel,
    input  logic [AW-1:0]           upd_val,
    input  logic [$clog2(NREG)-1:0] rd_isel,
    input  logic [$clog2(NREG)-1:0] rd_msel,
    output logic [AW-1:0]           rd_idx,
    output logic [AW-1:0]           rd_mod
);
    localparam int SW = $clog2(NREG);

    logic [AW-1:0] idx_q [NREG];
    logic [AW-1:0] mod_q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_entry
        // Index entry: software write outranks auto-update (R8)
        always_ff @(posedge clk) begin
            if (rst)
                idx_q[k] <= '0;
            else if (wr_en && !wr_is_mod && wr_sel == SW'(k))
                idx_q[k] <= wr_data;
            else if (upd_en && upd_sel == SW'(k))
                idx_q[k] <= upd_val;
        end

        always_ff @(posedge clk) begin
            if (rst)
                mod_q[k] <= '0;
            else if (wr_en && wr_is_mod && wr_sel == SW'(k))
                mod_q[k] <= wr_data;
        end
    end

    // Reads see pre-write contents (R9)
    assign rd_idx = idx_q[rd_isel];
    assign rd_mod = mod_q[rd_msel];
endmodule

// File: rtl/dag_unit.sv
module dag_unit
    import dag_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NREG    = 8,
    parameter bit JUMP_OK = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_is_mod,
    input  logic [$clog2(NREG)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    req,
    input  acc_mode_e               mode,
    input  logic [$clog2(NREG)-1:0] isel,
    input  logic [$clog2(NREG)-1:0] msel,
    output logic [AW-1:0]           addr,
    output logic                    valid,
    output logic                    is_jump
);
    logic [AW-1:0] idx_v, mod_v, sum_v, addr_n;
    logic          fire_data, fire_jump, do_upd;

    dag_regfile #(.AW(AW), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_is_mod(wr_is_mod),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .upd_en   (do_upd),
        .upd_sel  (isel),
        .upd_val  (sum_v),
        .rd_isel  (isel),
        .rd_msel  (msel),
        .rd_idx   (idx_v),
        .rd_mod   (mod_v)
    );

    // Two's-complement modifier, wraps modulo 2^AW (R10)
    assign sum_v = idx_v + mod_v;

    // Mode decode
    always_comb begin
        fire_data = 1'b0;
        fire_jump = 1'b0;
        do_upd    = 1'b0;
        addr_n    = sum_v;
        unique case (mode)
            ACC_OFFSET: begin
                fire_data = req;
            end
            ACC_POSTMOD: begin
                fire_data = req;
                do_upd    = req;
                addr_n    = idx_v;
            end
            ACC_JUMP: begin
                fire_jump = req && JUMP_OK;
            end
            ACC_NONE: begin
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            valid   <= 1'b0;
            is_jump <= 1'b0;
        end else begin
            valid   <= fire_data || fire_jump;
            is_jump <= fire_jump;
            if (fire_data || fire_jump)
                addr <= addr_n;
        end
    end
endmodule

// File: rtl/dual_dag.sv
module dual_dag
    import dag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_gen,
    input  logic                    wr_is_mod,
    input  logic [$clog2(NREG)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    dm_req,
    input  logic [1:0]              dm_mode,
    input  logic [$clog2(NREG)-1:0] dm_isel,
    input  logic [$clog2(NREG)-1:0] dm_msel,
    input  logic                    pm_req,
    input  logic [1:0]              pm_mode,
    input  logic [$clog2(NREG)-1:0] pm_isel,
    input  logic [$clog2(NREG)-1:0] pm_msel,
    output logic [AW-1:0]           dm_addr,
    output logic                    dm_valid,
    output logic [AW-1:0]           pm_addr,
    output logic                    pm_valid,
    output logic [AW-1:0]           jmp_addr,
    output logic                    jmp_valid
);
    localparam int SW    = $clog2(NREG);
    localparam int NUNIT = 2;

    logic          u_req   [NUNIT];
    acc_mode_e     u_mode  [NUNIT];
    logic [SW-1:0] u_isel  [NUNIT];
    logic [SW-1:0] u_msel  [NUNIT];
    logic [AW-1:0] u_addr  [NUNIT];
    logic          u_valid [NUNIT];
    logic          u_jump  [NUNIT];

    assign u_req[0]  = dm_req;
    assign u_mode[0] = acc_mode_e'(dm_mode);
    assign u_isel[0] = dm_isel;
    assign u_msel[0] = dm_msel;
    assign u_req[1]  = pm_req;
    assign u_mode[1] = acc_mode_e'(pm_mode);
    assign u_isel[1] = pm_isel;
    assign u_msel[1] = pm_msel;

    // Unit 0 serves data memory, unit 1 program memory and jumps
    for (genvar g = 0; g < NUNIT; g++) begin : g_unit
        dag_unit #(.AW(AW), .NREG(NREG), .JUMP_OK(g == 1)) u_dag (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_gen == 1'(g))),
            .wr_is_mod(wr_is_mod),
            .wr_sel   (wr_sel),
            .wr_data  (wr_data),
            .req      (u_req[g]),
            .mode     (u_mode[g]),
            .isel     (u_isel[g]),
            .msel     (u_msel[g]),
            .addr     (u_addr[g]),
            .valid    (u_valid[g]),
            .is_jump  (u_jump[g])
        );
    end

    assign dm_addr   = u_addr[0];
    assign dm_valid  = u_valid[0] && !u_jump[0];
    assign pm_addr   = u_addr[1];
    assign pm_valid  = u_valid[1] && !u_jump[1];
    assign jmp_addr  = u_addr[1];
    assign jmp_valid = u_valid[1] && u_jump[1];
endmodule

// File: rtl/dual_dag_chk.sv
module dual_dag_chk (
    input logic       clk,
    input logic       rst,
    input logic       dm_req,
    input logic [1:0] dm_mode,
    input logic       pm_req,
    input logic [1:0] pm_mode,
    input logic       dm_valid,
    input logic       pm_valid,
    input logic       jmp_valid
);
    // R1: reset quiets every strobe
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dm_valid && !pm_valid && !jmp_valid));

    // R3: data offset/post-modify request yields a strobe
    a_r3_dm_strobe: assert property (@(posedge clk) disable iff (rst)
        (dm_req && !dm_mode[1]) |=> dm_valid);

    // R5: program data request yields a data strobe, not a jump
    a_r5_pm_strobe: assert property (@(posedge clk) disable iff (rst)
        (pm_req && !pm_mode[1]) |=> (pm_valid && !jmp_valid));

    // R6: program jump request yields only the jump strobe
    a_r6_jump_only: assert property (@(posedge clk) disable iff (rst)
        (pm_req && pm_mode == 2'd2) |=> (jmp_valid && !pm_valid));

    // R7: ignored codes on data port raise nothing
    a_r7_dm_ignored: assert property (@(posedge clk) disable iff (rst)
        (dm_req && dm_mode[1]) |=> !dm_valid);

    // R7: code 3 on program port raises nothing
    a_r7_pm_ignored: assert property (@(posedge clk) disable iff (rst)
        (pm_req && pm_mode == 2'd3) |=> (!pm_valid && !jmp_valid));
endmodule

bind dual_dag dual_dag_chk u_chk (.*);

// File: tb/tb_dual_dag.sv
module tb_dual_dag;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NREG = 8;
    localparam int SW = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, wr_gen, wr_is_mod;
    logic [SW-1:0] wr_sel;
    logic [AW-1:0] wr_data;
    logic          dm_req, pm_req;
    logic [1:0]    dm_mode, pm_mode;
    logic [SW-1:0] dm_isel, dm_msel, pm_isel, pm_msel;
    logic [AW-1:0] dm_addr, pm_addr, jmp_addr;
    logic          dm_valid, pm_valid, jmp_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_dag #(.AW(AW), .NREG(NREG)) dut (.*);

    // op: 0 write, 1 access; data = write value or expected address
    typedef struct packed {
        logic       op;
        logic       gen;
        logic       is_mod;
        logic [2:0] isel;
        logic [2:0] msel;
        logic [1:0] mode;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 2'd0, 32'h0000_0100}, // R2 index
        '{1'b0, 1'b0, 1'b1, 3'd2, 3'd0, 2'd0, 32'h0000_0004}, // R2 modifier
        '{1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 2'd0, 32'h0000_0104}, // R3
        '{1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 2'd0, 32'h0000_0104}, // R3 no update
        '{1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 2'd1, 32'h0000_0100}, // R4
        '{1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 2'd1, 32'h0000_0104}, // R4
        '{1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 2'd0, 32'h0000_010C}, // R4
        '{1'b0, 1'b1, 1'b0, 3'd3, 3'd0, 2'd0, 32'h0000_2000},
        '{1'b0, 1'b1, 1'b1, 3'd5, 3'd0, 2'd0, 32'hFFFF_FFF8},
        '{1'b1, 1'b1, 1'b0, 3'd3, 3'd5, 2'd1, 32'h0000_2000}, // R10 neg
        '{1'b1, 1'b1, 1'b0, 3'd3, 3'd5, 2'd0, 32'h0000_1FF0}, // R10
        '{1'b1, 1'b1, 1'b0, 3'd3, 3'd5, 2'd2, 32'h0000_1FF0}, // R6
        '{1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 2'd0, 32'h0000_010C}  // R5 isolation
    };

    task automatic chk(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_gen = 0; wr_is_mod = 0; wr_sel = '0; wr_data = '0;
        dm_req = 0; dm_mode = '0; dm_isel = '0; dm_msel = '0;
        pm_req = 0; pm_mode = '0; pm_isel = '0; pm_msel = '0;
    endtask

    task automatic wr(input logic g, input logic m, input logic [SW-1:0] s,
                      input logic [AW-1:0] d);
        wr_en = 1; wr_gen = g; wr_is_mod = m; wr_sel = s; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    // Request at one negedge; result registered at next posedge, sampled next negedge
    task automatic acc(input logic g, input logic [1:0] md,
                       input logic [SW-1:0] i, input logic [SW-1:0] m);
        if (g) begin pm_req = 1; pm_mode = md; pm_isel = i; pm_msel = m; end
        else   begin dm_req = 1; dm_mode = md; dm_isel = i; dm_msel = m; end
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: strobes low and registers zero after reset
        chk("R1 dm_valid", AW'(dm_valid), '0);
        chk("R1 pm_valid", AW'(pm_valid), '0);
        chk("R1 jmp_valid", AW'(jmp_valid), '0);
        acc(1'b0, 2'd0, 3'd7, 3'd7);
        chk("R1 dm zero regs", dm_addr, '0);
        acc(1'b1, 2'd0, 3'd6, 3'd4);
        chk("R1 pm zero regs", pm_addr, '0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            if (!VEC[v].op) begin
                wr(VEC[v].gen, VEC[v].is_mod, VEC[v].isel, VEC[v].data);
            end else begin
                acc(VEC[v].gen, VEC[v].mode, VEC[v].isel, VEC[v].msel);
                if (!VEC[v].gen) begin
                    chk("R3/R4 dm_valid", AW'(dm_valid), 1);
                    chk("R3/R4 dm_addr", dm_addr, VEC[v].data);
                end else if (VEC[v].mode == 2'd2) begin
                    chk("R6 jmp_valid", AW'(jmp_valid), 1);
                    chk("R6 pm_valid low", AW'(pm_valid), 0);
                    chk("R6 jmp_addr", jmp_addr, VEC[v].data);
                end else begin
                    chk("R10 pm_valid", AW'(pm_valid), 1);
                    chk("R10 pm_addr", pm_addr, VEC[v].data);
                end
            end
        end

        // R5: both ports in the same cycle
        dm_req = 1; dm_mode = 2'd1; dm_isel = 3'd1; dm_msel = 3'd2;
        pm_req = 1; pm_mode = 2'd0; pm_isel = 3'd3; pm_msel = 3'd5;
        @(negedge clk);
        idle();
        chk("R5 dm_addr", dm_addr, 32'h0000_0108);
        chk("R5 pm_addr", pm_addr, 32'h0000_1FF0);
        chk("R5 both strobes", AW'({dm_valid, pm_valid}), 2'b11);

        // R7: jump code on data port, code 3 on program port
        acc(1'b0, 2'd2, 3'd1, 3'd2);
        chk("R7 dm jump ignored", AW'({dm_valid, jmp_valid}), 0);
        acc(1'b0, 2'd3, 3'd1, 3'd2);
        chk("R7 dm code3 ignored", AW'(dm_valid), 0);
        acc(1'b1, 2'd3, 3'd3, 3'd5);
        chk("R7 pm code3 ignored", AW'({pm_valid, jmp_valid}), 0);
        acc(1'b0, 2'd0, 3'd1, 3'd2);
        chk("R7 dm index untouched", dm_addr, 32'h0000_0110);

        // R8 + R9: write and post-modify on same index register
        wr(1'b0, 1'b0, 3'd4, 32'h0000_0040);
        wr(1'b0, 1'b1, 3'd0, 32'h0000_0010);
        wr_en = 1; wr_gen = 0; wr_is_mod = 0; wr_sel = 3'd4; wr_data = 32'h0000_0500;
        dm_req = 1; dm_mode = 2'd1; dm_isel = 3'd4; dm_msel = 3'd0;
        @(negedge clk);
        idle();
        chk("R9 read before write", dm_addr, 32'h0000_0040);
        acc(1'b0, 2'd0, 3'd4, 3'd0);
        chk("R8 write beats update", dm_addr, 32'h0000_0510);

        // R9: offset read in same cycle as write to its index
        wr_en = 1; wr_gen = 0; wr_is_mod = 0; wr_sel = 3'd6; wr_data = 32'h0000_0077;
        dm_req = 1; dm_mode = 2'd0; dm_isel = 3'd6; dm_msel = 3'd0;
        @(negedge clk);
        idle();
        chk("R9 old index used", dm_addr, 32'h0000_0010);
        acc(1'b0, 2'd0, 3'd6, 3'd0);
        chk("R9 new index next", dm_addr, 32'h0000_0087);

        // R10: upward wrap
        wr(1'b0, 1'b0, 3'd0, 32'hFFFF_FFFC);
        wr(1'b0, 1'b1, 3'd1, 32'h0000_0008);
        acc(1'b0, 2'd1, 3'd0, 3'd1);
        chk("R10 pre-wrap addr", dm_addr, 32'hFFFF_FFFC);
        acc(1'b0, 2'd0, 3'd0, 3'd1);
        chk("R10 wrapped", dm_addr, 32'h0000_000C);

        // R5: program writes left data register 1 alone
        acc(1'b0, 2'd0, 3'd1, 3'd2);
        chk("R5 isolation", dm_addr, 32'h0000_0110);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule